// File: doc/BRIEF.md
# Multiply-Add Addend Alignment Shifter

This combinational stage places the 53-bit significand of the addend of a double-precision fused multiply-add into a wide window that is fixed relative to the 106-bit product of the other two significands. The product itself never moves. Only the addend is shifted, so the alignment can be computed while the partial products are still being accumulated.

The shift is set by the exponent difference d = EA + EB − bias − EC, formed in signed arithmetic wide enough for any pair of biased exponents. A positive d moves the addend toward the low end of the window, and a negative d moves it toward the high end.

The window is 161 bits wide. Positions are numbered from 0 at the bottom. Positions 0 and 1 are guard positions, positions 2..107 hold the product, and positions 108..160 sit above the product. Addend bits that fall below position 0 are ORed into a sticky bit. When the addend sits so far above the product that the product only matters as a sticky indication, a separate flag reports it and the addend is held at the top of the window.

Top module: `fam_addend_align`

## Requirements
- R1: With bias 1023 and d = EA+EB−1023−EC, for −54 ≤ d ≤ 54 addend bit i lands at window position 54−d+i, all other window positions are 0, and the sticky output is 0.
- R2: When d = 0, the addend occupies window positions 54..106, so its top bit lines up with the product's second-highest position.
- R3: For 55 ≤ d ≤ 106, addend bits whose position 54−d+i is at least 0 appear in the window. The sticky output is the OR of the addend bits whose position would be negative.
- R4: For d ≥ 107, the window is all zero and the sticky output equals the OR of all 53 addend bits.
- R5: For d ≤ −54, the product-dropped output is 1, the addend occupies window positions 108..160 exactly, and the sticky output is 0.
- R6: For d ≥ −53, the product-dropped output is 0.
- R7: An all-zero addend gives an all-zero window and a zero sticky output for every d. No shift ever creates or destroys a set bit inside the shifter.
- R8: The extreme exponents (EA = EB = 2047 with EC = 0, and EA = EB = 0 with EC = 2047) do not wrap. The first behaves as a far right shift (R4) and the second as a dropped product (R5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| c_sig | input | 53 | Addend significand, hidden bit included |
| ea | input | 11 | Biased exponent of the first factor |
| eb | input | 11 | Biased exponent of the second factor |
| ec | input | 11 | Biased exponent of the addend |
| aligned | output | 161 | Aligned addend window, product LSB at position 2 |
| addend_sticky | output | 1 | OR of addend bits shifted below position 0 |
| product_dropped | output | 1 | Product lies wholly below the addend and is sticky-only |

## Verification
Two functions can act on the same input: the window placement and the sticky collection. Whenever d lies between 55 and 106, the addend is split between them. The bench drives patterns whose low bits differ from their high bits across that band, so that a wrong split point shows up in both outputs at once. Each result is judged against a reference that shifts with unbounded width.

The other meeting point is the pair d = −54 and d = −53. There the product-dropped flag turns on while the placement is still exact, and both values are compared in that same evaluation.

// File: rtl/fam_align_pkg.sv
package fam_align_pkg;

    localparam int SIG_W    = 53;
    localparam int EXP_W    = 11;
    localparam int GUARD_W  = 2;
    localparam int EXP_BIAS = (1 << (EXP_W - 1)) - 1;

    localparam int PROD_W = 2 * SIG_W;
    localparam int WIN_W  = SIG_W + PROD_W + GUARD_W;
    localparam int EXT_W  = WIN_W + SIG_W;
    localparam int D_W    = EXP_W + 3;

    // window position of the addend LSB when d == 0
    localparam int C_LSB0 = GUARD_W + SIG_W - 1;
    // most negative useful d: addend top-justified in the window
    localparam int D_MIN  = C_LSB0 - (WIN_W - SIG_W);
    // first d for which the whole addend is below the window
    localparam int D_MAX  = C_LSB0 + SIG_W;
    localparam int SH_MAX = SIG_W + C_LSB0 - D_MIN;
    localparam int SH_W   = $clog2(SH_MAX + 1);

    typedef logic signed [D_W-1:0] exp_diff_t;

    typedef struct packed {
        logic            prod_dropped;
        logic [SH_W-1:0] shamt;
    } align_ctl_t;

    function automatic exp_diff_t clamp_diff(input exp_diff_t d);
        exp_diff_t lo;
        exp_diff_t hi;
        lo = exp_diff_t'(D_MIN);
        hi = exp_diff_t'(D_MAX);
        if (d < lo)      return lo;
        else if (d > hi) return hi;
        else             return d;
    endfunction

endpackage

// File: rtl/fam_expdiff.sv
module fam_expdiff
    import fam_align_pkg::*;
(
    input  logic [EXP_W-1:0] ea,
    input  logic [EXP_W-1:0] eb,
    input  logic [EXP_W-1:0] ec,
    output exp_diff_t        diff,
    output align_ctl_t       ctl
);

    exp_diff_t sa, sb, sc, dcl, amt;

    always_comb begin
        sa   = exp_diff_t'({3'b000, ea});
        sb   = exp_diff_t'({3'b000, eb});
        sc   = exp_diff_t'({3'b000, ec});
        diff = sa + sb - exp_diff_t'(EXP_BIAS) - sc;
        dcl  = clamp_diff(diff);
        amt  = exp_diff_t'(SIG_W + C_LSB0) - dcl;
        ctl.shamt        = amt[SH_W-1:0];
        ctl.prod_dropped = (diff <= exp_diff_t'(D_MIN));
    end

    always_comb begin
        if (!$isunknown({ea, eb, ec})) begin
            // R8: clamped shift amount stays within the extended vector
            a_r8_shamt_range: assert (amt >= 0 && amt <= exp_diff_t'(SH_MAX));
        end
    end

endmodule

// File: rtl/fam_barrel_left.sv
module fam_barrel_left #(
    parameter int DATA_W = 214,
    parameter int AMT_W  = 8
) (
    input  logic [DATA_W-1:0] din,
    input  logic [AMT_W-1:0]  amt,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] stg [AMT_W+1];

    assign stg[0] = din;

    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        assign stg[s+1] = amt[s] ? (stg[s] << (2 ** s)) : stg[s];
    end

    assign dout = stg[AMT_W];

endmodule

// File: rtl/fam_window_split.sv
module fam_window_split
    import fam_align_pkg::*;
(
    input  logic [EXT_W-1:0] ext,
    output logic [WIN_W-1:0] window,
    output logic             sticky
);

    assign window = ext[EXT_W-1 -: WIN_W];
    assign sticky = |ext[SIG_W-1:0];

endmodule

// File: rtl/fam_addend_align.sv
module fam_addend_align
    import fam_align_pkg::*;
(
    input  logic [SIG_W-1:0] c_sig,
    input  logic [EXP_W-1:0] ea,
    input  logic [EXP_W-1:0] eb,
    input  logic [EXP_W-1:0] ec,
    output logic [WIN_W-1:0] aligned,
    output logic             addend_sticky,
    output logic             product_dropped
);

    exp_diff_t         diff;
    align_ctl_t        ctl;
    logic [EXT_W-1:0]  ext_in;
    logic [EXT_W-1:0]  ext_sh;

    fam_expdiff u_expdiff (
        .ea   (ea),
        .eb   (eb),
        .ec   (ec),
        .diff (diff),
        .ctl  (ctl)
    );

    assign ext_in = {{(EXT_W - SIG_W){1'b0}}, c_sig};

    fam_barrel_left #(
        .DATA_W (EXT_W),
        .AMT_W  (SH_W)
    ) u_shift (
        .din  (ext_in),
        .amt  (ctl.shamt),
        .dout (ext_sh)
    );

    fam_window_split u_split (
        .ext    (ext_sh),
        .window (aligned),
        .sticky (addend_sticky)
    );

    assign product_dropped = ctl.prod_dropped;

    always_comb begin
        if (!$isunknown({c_sig, ea, eb, ec})) begin
            // R5: a dropped product leaves the addend top-justified
            if (product_dropped)
                a_r5_drop_top: assert (aligned[WIN_W-1 -: SIG_W] == c_sig);
            // R1: no addend bit is lost inside the exact range
            if (diff <= exp_diff_t'(C_LSB0))
                a_r1_exact_no_sticky: assert (!addend_sticky);
            // R4: far right shift empties the window
            if (diff >= exp_diff_t'(D_MAX))
                a_r4_far_empty: assert (aligned == '0);
            // R7: the shifter conserves set bits
            a_r7_conserve: assert ($countones(ext_sh) == $countones(c_sig));
        end
    end

endmodule

// File: tb/fam_addend_align_bench.sv
module fam_addend_align_bench;
    import fam_align_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [SIG_W-1:0] c_sig;
    logic [EXP_W-1:0] ea, eb, ec;
    logic [WIN_W-1:0] aligned;
    logic             addend_sticky, product_dropped;

    fam_addend_align u_fam_addend_align (
        .c_sig           (c_sig),
        .ea              (ea),
        .eb              (eb),
        .ec              (ec),
        .aligned         (aligned),
        .addend_sticky   (addend_sticky),
        .product_dropped (product_dropped)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    int cycles   = 0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    // unbounded-width reference and comparison of one input set
    task automatic apply(input logic [SIG_W-1:0] c, input int a, input int b,
                         input int e, input string req);
        int d, pos;
        logic [WIN_W-1:0] w;
        logic st, dr;
        @(posedge clk);
        c_sig = c; ea = EXP_W'(a); eb = EXP_W'(b); ec = EXP_W'(e);
        d  = a + b - 1023 - e;
        dr = (d <= -54);
        pos = dr ? 108 : 54 - d;
        w = '0; st = 1'b0;
        for (int i = 0; i < SIG_W; i++) begin
            if (c[i]) begin
                if (pos + i >= 0) w[pos + i] = 1'b1;
                else st = 1'b1;
            end
        end
        @(negedge clk);
        n_checks++;
        if (aligned !== w || addend_sticky !== st || product_dropped !== dr) begin
            n_fail++;
            $display("FAIL %s d=%0d: actual win=%h st=%b dr=%b expected win=%h st=%b dr=%b",
                     req, d, aligned, addend_sticky, product_dropped, w, st, dr);
        end
    endtask

    task automatic with_d(input logic [SIG_W-1:0] c, input int d, input string req);
        apply(c, 1023, 1023, 1023 - d, req);
    endtask

    function automatic logic [SIG_W-1:0] pat(input int k);
        logic [63:0] x;
        x = 64'h9E3779B97F4A7C15 * (k + 1);
        x = x ^ (x >> 29);
        return {1'b1, x[SIG_W-2:0]};
    endfunction

    task automatic t_idle;      // all-zero inputs: d = -1023
        apply('0, 0, 0, 0, "R7 R5 idle");
    endtask

    task automatic t_center;
        with_d({SIG_W{1'b1}}, 0, "R2");
        with_d({1'b1, {(SIG_W-2){1'b0}}, 1'b1}, 0, "R2");
    endtask

    task automatic t_exact;
        for (int d = -54; d <= 54; d++) with_d(pat(d + 100), d, "R1");
        with_d({SIG_W{1'b1}}, 53, "R1");
        with_d({SIG_W{1'b1}}, 54, "R1");
        with_d({SIG_W{1'b1}}, -53, "R1");
    endtask

    task automatic t_split;
        for (int d = 55; d <= 106; d++) begin
            with_d(pat(d), d, "R3");
            with_d({1'b1, {(SIG_W-1){1'b0}}}, d, "R3");
            with_d({{(SIG_W-1){1'b0}}, 1'b1}, d, "R3");
        end
    endtask

    task automatic t_far;
        with_d({SIG_W{1'b1}}, 107, "R4");
        with_d({{(SIG_W-1){1'b0}}, 1'b1}, 200, "R4");
        with_d(pat(7), 1000, "R4");
    endtask

    task automatic t_drop;
        with_d(pat(3), -54, "R5");
        with_d(pat(4), -55, "R5");
        with_d({SIG_W{1'b1}}, -900, "R5");
        with_d(pat(5), -53, "R6");
        with_d(pat(6), -52, "R6");
    endtask

    task automatic t_zero;
        for (int d = -60; d <= 120; d += 15) with_d('0, d, "R7");
    endtask

    task automatic t_extreme;
        apply({SIG_W{1'b1}}, 2047, 2047, 0, "R8 R4");
        apply(pat(9), 0, 0, 2047, "R8 R5");
    endtask

    initial begin
        c_sig = '0; ea = '0; eb = '0; ec = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_idle();
        t_center();
        t_exact();
        t_split();
        t_far();
        t_drop();
        t_zero();
        t_extreme();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule